// File: doc/BRIEF.md
# DDR 4:2:2 Video Input Deinterleaver

The block receives one 10-bit video bus on which luma and chroma take turns on the two edges of a single pixel clock. It samples the bus on both edges and rebuilds, once per rising edge, a parallel pair made of one luma word and one chroma word. A downstream single-data-rate pipeline can then take the pair directly. A 2-bit configuration field picks which of the two edges carries luma. A width select turns on 8-bit operation, in which only the upper eight bus bits carry data.

The block also tracks the Cb/Cr alternation of the 4:2:2 chroma. It watches the interleaved stream for embedded timing reference codes, which are an all-ones word followed by two zero words and a status word. When it finds one, it raises a one-cycle marker, presents the status word, and withholds both preamble pairs from the valid stream. The next valid pair is forced back to the Cb phase.

Timing is counted in pairs. A pair is the word on a rising edge together with the word on the falling edge that follows it.

Top module: `ddr422_deinterleave`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it falls, `pair_valid_o`, `trc_pulse_o` and `cr_phase_o` are 0.
- R2: With `luma_edge_cfg_i` = 2'b00, `luma_o` is the word sampled on the rising edge of a pair. `chroma_o` is the word sampled on the falling edge that follows it.
- R3: With `luma_edge_cfg_i` = 2'b11, `chroma_o` is the rising-edge word of a pair and `luma_o` is the falling-edge word.
- R4: The field values 2'b01 and 2'b10 give exactly the mapping of 2'b00.
- R5: One pair is produced per clock. A pair whose first word is sampled on rising edge k shows its outputs, with `pair_valid_o` high, after rising edge k+2. `pair_valid_o` is low after edge k+1 when edge k is the first edge out of reset.
- R6: `cr_phase_o` is 0 for Cb and 1 for Cr. It is Cb for the first valid pair after reset and inverts after every valid pair.
- R7: With `narrow_i` = 1, bus bits [1:0] are ignored. The data is taken from bits [9:2], and bits [1:0] of `luma_o` and `chroma_o` are 0.
- R8: Consider two consecutive pairs whose words, in time order, are ONES, 0, 0 and XY. ONES is 0x3FF in 10-bit mode and 0x3FC after masking in 8-bit mode. For such pairs `trc_pulse_o` is high for one cycle in the first pair's output slot, with `trc_word_o` = XY. `pair_valid_o` is low in both slots. A pair of ONES, 0 followed by a pair whose first word is non-zero is ordinary data.
- R9: The first valid pair after a timing reference has `cr_phase_o` = 0 (Cb).
- R10: `pair_valid_o` and `trc_pulse_o` are never high together, and `trc_pulse_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| ddr_bus_i | input | 10 | Interleaved luma/chroma bus |
| luma_edge_cfg_i | input | 2 | 2'b11: luma on falling edge; other values: luma on rising edge |
| narrow_i | input | 1 | 1 selects 8-bit data on bits [9:2] |
| luma_o | output | 10 | Rebuilt luma word |
| chroma_o | output | 10 | Rebuilt chroma word |
| cr_phase_o | output | 1 | 0 = Cb, 1 = Cr for the current pair |
| pair_valid_o | output | 1 | High for one cycle per delivered pair |
| trc_pulse_o | output | 1 | One-cycle timing reference marker |
| trc_word_o | output | 10 | Status word of the last timing reference |

## Verification
On every cycle, the assertions check that the valid strobe and the reference marker are exclusive and that the marker is a single cycle wide. They also check that the phase flag inverts after each valid pair and returns to Cb after a marker, that 8-bit mode leaves the low bits clear, and that reset clears the outputs. Other behaviours depend on the stimulus that preceded them, so only the bench scenarios can show them. These are the edge-to-word mapping for each configuration value (reserved ones included), the exact two-edge latency, a near-miss preamble passing as data, and back-to-back references.

// File: rtl/ddr422_pkg.sv
`timescale 1ns/1ps
package ddr422_pkg;

    localparam int PIX_W_DEF    = 10;
    localparam int NARROW_W_DEF = 8;

    typedef enum logic {
        CHROMA_CB = 1'b0,
        CHROMA_CR = 1'b1
    } chroma_phase_e;

    typedef enum logic [1:0] {
        EDGE_LUMA_RISE = 2'b00,
        EDGE_RSV_A     = 2'b01,
        EDGE_RSV_B     = 2'b10,
        EDGE_LUMA_FALL = 2'b11
    } edge_cfg_e;

    // Reserved codes collapse onto the luma-on-rise ordering.
    function automatic logic luma_on_fall(input logic [1:0] cfg);
        return edge_cfg_e'(cfg) == EDGE_LUMA_FALL;
    endfunction

    function automatic chroma_phase_e next_phase(input chroma_phase_e ph);
        return (ph == CHROMA_CB) ? CHROMA_CR : CHROMA_CB;
    endfunction

endpackage

// File: rtl/ddr_edge_capture.sv
`timescale 1ns/1ps
module ddr_edge_capture #(
    parameter int PIX_W    = ddr422_pkg::PIX_W_DEF,
    parameter int NARROW_W = ddr422_pkg::NARROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] bus_i,
    input  logic             narrow_i,
    output logic [PIX_W-1:0] early_o,
    output logic [PIX_W-1:0] late_o,
    output logic             pair_ok_o
);
    localparam int               DROP      = PIX_W - NARROW_W;
    localparam logic [PIX_W-1:0] FULL_MASK = '1;
    localparam logic [PIX_W-1:0] KEEP_MASK = FULL_MASK << DROP;

    logic [PIX_W-1:0] bus_n;

    always_comb bus_n = narrow_i ? (bus_i & KEEP_MASK) : bus_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            early_o   <= '0;
            pair_ok_o <= 1'b0;
        end else begin
            early_o   <= bus_n;
            pair_ok_o <= 1'b1;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) late_o <= '0;
        else     late_o <= bus_n;
    end
endmodule

// File: rtl/trc_guard.sv
`timescale 1ns/1ps
module trc_guard #(
    parameter int PIX_W    = ddr422_pkg::PIX_W_DEF,
    parameter int NARROW_W = ddr422_pkg::NARROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             narrow_i,
    input  logic [PIX_W-1:0] early_i,
    input  logic [PIX_W-1:0] late_i,
    input  logic             pair_ok_i,
    output logic [PIX_W-1:0] held_early_o,
    output logic [PIX_W-1:0] held_late_o,
    output logic             held_ok_o,
    output logic             ref_hit_o,
    output logic [PIX_W-1:0] xy_o
);
    localparam int               DROP      = PIX_W - NARROW_W;
    localparam logic [PIX_W-1:0] FULL_ONES = '1;
    localparam logic [PIX_W-1:0] NARR_ONES = FULL_ONES << DROP;

    logic [PIX_W-1:0] ones_pat;

    always_comb begin
        ones_pat  = narrow_i ? NARR_ONES : FULL_ONES;
        ref_hit_o = held_ok_o && pair_ok_i &&
                    (held_early_o == ones_pat) && (held_late_o == '0) &&
                    (early_i == '0);
        xy_o      = late_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_early_o <= '0;
            held_late_o  <= '0;
            held_ok_o    <= 1'b0;
        end else begin
            held_early_o <= early_i;
            held_late_o  <= late_i;
            held_ok_o    <= pair_ok_i && !ref_hit_o;
        end
    end
endmodule

// File: rtl/yc_output_stage.sv
`timescale 1ns/1ps
module yc_output_stage
    import ddr422_pkg::*;
#(
    parameter int PIX_W = ddr422_pkg::PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       edge_cfg_i,
    input  logic [PIX_W-1:0] held_early_i,
    input  logic [PIX_W-1:0] held_late_i,
    input  logic             held_ok_i,
    input  logic             ref_hit_i,
    input  logic [PIX_W-1:0] xy_i,
    output logic [PIX_W-1:0] luma_o,
    output logic [PIX_W-1:0] chroma_o,
    output logic             cr_phase_o,
    output logic             pair_valid_o,
    output logic             trc_pulse_o,
    output logic [PIX_W-1:0] trc_word_o
);
    chroma_phase_e phase_q;
    logic          deliver;

    always_comb deliver = held_ok_i && !ref_hit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            luma_o       <= '0;
            chroma_o     <= '0;
            cr_phase_o   <= 1'b0;
            pair_valid_o <= 1'b0;
            trc_pulse_o  <= 1'b0;
            trc_word_o   <= '0;
            phase_q      <= CHROMA_CB;
        end else begin
            pair_valid_o <= deliver;
            trc_pulse_o  <= ref_hit_i;
            cr_phase_o   <= (phase_q == CHROMA_CR);
            if (ref_hit_i) trc_word_o <= xy_i;
            if (deliver) begin
                if (luma_on_fall(edge_cfg_i)) begin
                    luma_o   <= held_late_i;
                    chroma_o <= held_early_i;
                end else begin
                    luma_o   <= held_early_i;
                    chroma_o <= held_late_i;
                end
            end
            if (ref_hit_i)    phase_q <= CHROMA_CB;
            else if (deliver) phase_q <= next_phase(phase_q);
        end
    end
endmodule

// File: rtl/ddr422_deinterleave.sv
`timescale 1ns/1ps
module ddr422_deinterleave #(
    parameter int PIX_W    = ddr422_pkg::PIX_W_DEF,
    parameter int NARROW_W = ddr422_pkg::NARROW_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] ddr_bus_i,
    input  logic [1:0]       luma_edge_cfg_i,
    input  logic             narrow_i,
    output logic [PIX_W-1:0] luma_o,
    output logic [PIX_W-1:0] chroma_o,
    output logic             cr_phase_o,
    output logic             pair_valid_o,
    output logic             trc_pulse_o,
    output logic [PIX_W-1:0] trc_word_o
);
    logic [PIX_W-1:0] early_w, late_w, held_early_w, held_late_w, xy_w;
    logic             pair_ok_w, held_ok_w, ref_hit_w;

    ddr_edge_capture #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) cap_i (
        .clk(clk), .rst(rst), .bus_i(ddr_bus_i), .narrow_i(narrow_i),
        .early_o(early_w), .late_o(late_w), .pair_ok_o(pair_ok_w)
    );

    trc_guard #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) guard_i (
        .clk(clk), .rst(rst), .narrow_i(narrow_i),
        .early_i(early_w), .late_i(late_w), .pair_ok_i(pair_ok_w),
        .held_early_o(held_early_w), .held_late_o(held_late_w),
        .held_ok_o(held_ok_w), .ref_hit_o(ref_hit_w), .xy_o(xy_w)
    );

    yc_output_stage #(.PIX_W(PIX_W)) out_i (
        .clk(clk), .rst(rst), .edge_cfg_i(luma_edge_cfg_i),
        .held_early_i(held_early_w), .held_late_i(held_late_w),
        .held_ok_i(held_ok_w), .ref_hit_i(ref_hit_w), .xy_i(xy_w),
        .luma_o(luma_o), .chroma_o(chroma_o), .cr_phase_o(cr_phase_o),
        .pair_valid_o(pair_valid_o), .trc_pulse_o(trc_pulse_o),
        .trc_word_o(trc_word_o)
    );
endmodule

// File: rtl/ddr422_deint_chk.sv
`timescale 1ns/1ps
module ddr422_deint_chk #(
    parameter int PIX_W    = ddr422_pkg::PIX_W_DEF,
    parameter int NARROW_W = ddr422_pkg::NARROW_W_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic             narrow_i,
    input logic [PIX_W-1:0] luma_o,
    input logic [PIX_W-1:0] chroma_o,
    input logic             cr_phase_o,
    input logic             pair_valid_o,
    input logic             trc_pulse_o
);
    localparam int               DROP      = PIX_W - NARROW_W;
    localparam logic [PIX_W-1:0] FULL_MASK = '1;
    localparam logic [PIX_W-1:0] LOW_MASK  = ~(FULL_MASK << DROP);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pair_valid_o && !trc_pulse_o && !cr_phase_o));

    // R10
    valid_marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pair_valid_o && trc_pulse_o));

    // R10
    marker_single_chk: assert property (@(posedge clk) disable iff (rst)
        trc_pulse_o |=> !trc_pulse_o);

    // R8
    preamble_gap_chk: assert property (@(posedge clk) disable iff (rst)
        trc_pulse_o |=> !pair_valid_o);

    // R6
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |=> (cr_phase_o != $past(cr_phase_o)));

    // R9
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        trc_pulse_o |=> !cr_phase_o);

    // R7
    narrow_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_valid_o && narrow_i && $past(narrow_i) && $past(narrow_i, 2) &&
         $past(narrow_i, 3))
        |-> (((luma_o & LOW_MASK) == '0) && ((chroma_o & LOW_MASK) == '0)));
endmodule

bind ddr422_deinterleave ddr422_deint_chk #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) chk_i (
    .clk(clk), .rst(rst), .narrow_i(narrow_i),
    .luma_o(luma_o), .chroma_o(chroma_o), .cr_phase_o(cr_phase_o),
    .pair_valid_o(pair_valid_o), .trc_pulse_o(trc_pulse_o)
);

// File: tb/ddr422_deinterleave_tb.sv
`timescale 1ns/1ps
module ddr422_deinterleave_tb_top;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] bus = '0;
    logic [1:0] cfg = 2'b00;
    logic       narrow = 1'b0;
    logic [9:0] luma, chroma, trc_word;
    logic       cr_phase, pair_valid, trc_pulse;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [9:0] pa [NP];
    logic [9:0] pb [NP];

    always #2.5 clk = ~clk;

    ddr422_deinterleave dut_i (
        .clk(clk), .rst(rst), .ddr_bus_i(bus), .luma_edge_cfg_i(cfg),
        .narrow_i(narrow), .luma_o(luma), .chroma_o(chroma),
        .cr_phase_o(cr_phase), .pair_valid_o(pair_valid),
        .trc_pulse_o(trc_pulse), .trc_word_o(trc_word)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] nm(input logic [9:0] x, input logic nw);
        return nw ? (x & 10'h3FC) : x;
    endfunction

    // kind 0: reference at pairs 4/5, near-miss at 9/10
    // kind 1: back-to-back references at pairs 2/3 and 4/5
    task automatic fill(input int sel, input int nw, input int kind);
        for (int j = 0; j < NP; j++) begin
            pa[j] = 10'((j * 73 + sel * 29 + nw * 11 + 40) % 1024);
            pb[j] = 10'((j * 131 + sel * 17 + 600) % 1024);
        end
        if (kind == 0) begin
            pa[4] = nw ? 10'h3FE : 10'h3FF;  pb[4] = nw ? 10'h002 : 10'h000;
            pa[5] = nw ? 10'h001 : 10'h000;  pb[5] = 10'(10'h2D8 + sel);
            pa[9] = 10'h3FF;  pb[9] = 10'h000;
            pa[10] = 10'h155; pb[10] = 10'h0F0;
        end else begin
            pa[2] = 10'h3FF; pb[2] = 10'h000; pa[3] = 10'h000; pb[3] = 10'h2AC;
            pa[4] = 10'h3FF; pb[4] = 10'h000; pa[5] = 10'h000; pb[5] = 10'h1B4;
        end
    endtask

    task automatic run_scn(input int sel, input int nw, input int kind);
        bit refst [NP];
        bit eaten [NP];
        logic [9:0] ones;
        string mtag;
        fill(sel, nw, kind);
        ones = nw ? 10'h3FC : 10'h3FF;
        for (int j = 0; j < NP; j++) begin refst[j] = 0; eaten[j] = 0; end
        for (int j = 0; j < NP - 1; j++)
            if (!eaten[j] && nm(pa[j], nw) == ones && nm(pb[j], nw) == 10'h0 &&
                nm(pa[j+1], nw) == 10'h0) begin
                refst[j] = 1; eaten[j+1] = 1;
            end
        mtag = nw ? "R7" : (sel == 0 ? "R2" : (sel == 3 ? "R3" : "R4"));

        rst = 1'b1; bus = '0;
        @(posedge clk); #0.5;
        cfg = 2'(sel); narrow = nw[0];
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(pair_valid), 0);
        check("R1 marker in reset", int'(trc_pulse), 0);
        check("R1 phase in reset", int'(cr_phase), 0);

        fork
            begin
                for (int j = 0; j < NP; j++) begin
                    @(negedge clk); #1.25;
                    if (j == 0) rst = 1'b0;
                    bus = pa[j];
                    @(posedge clk); #1.25;
                    bus = pb[j];
                end
            end
            begin
                bit ph;
                bit after_ref;
                ph = 0; after_ref = 0;
                @(negedge clk);
                @(posedge clk);
                @(posedge clk); #1;
                check("R1 R5 valid one edge after first sample", int'(pair_valid), 0);
                check("R1 phase after reset", int'(cr_phase), 0);
                @(posedge clk); #1;
                for (int j = 0; j < NP; j++) begin
                    check("R10 valid and marker exclusive",
                          int'(pair_valid && trc_pulse), 0);
                    if (refst[j]) begin
                        check("R8 marker", int'(trc_pulse), 1);
                        check("R8 valid low on preamble", int'(pair_valid), 0);
                        check("R8 status word", int'(trc_word), int'(nm(pb[j+1], nw)));
                        ph = 0; after_ref = 1;
                    end else if (eaten[j]) begin
                        check("R8 valid low on status pair", int'(pair_valid), 0);
                        check("R10 marker width", int'(trc_pulse), 0);
                    end else begin
                        check("R5 valid", int'(pair_valid), 1);
                        check("R8 no marker on data", int'(trc_pulse), 0);
                        check({mtag, " luma"}, int'(luma),
                              int'(sel == 3 ? nm(pb[j], nw) : nm(pa[j], nw)));
                        check({mtag, " chroma"}, int'(chroma),
                              int'(sel == 3 ? nm(pa[j], nw) : nm(pb[j], nw)));
                        check(after_ref ? "R9 phase" : "R6 phase", int'(cr_phase), int'(ph));
                        ph = !ph; after_ref = 0;
                    end
                    @(posedge clk); #1;
                end
            end
        join
    endtask

    initial begin
        for (int sel = 0; sel < 4; sel++)
            for (int nw = 0; nw < 2; nw++)
                run_scn(sel, nw, 0);
        run_scn(0, 0, 1);
        run_scn(3, 1, 1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule